// File: doc/BRIEF.md
# Private cache line coherence controller

This block keeps the coherence state of one line of a private first-level cache that takes part in a directory-based MOESI protocol. The processor side presents loads, stores and replacements. The block either completes each one in the same cycle or stalls it, holding it until the line reaches a state where it can finish. The network side delivers data replies, acknowledgment counts, invalidations and forwarded requests. Toward the shared level the block emits read-shared and read-exclusive requests, writebacks, forwarded data and invalidation acknowledgments, one message per cycle at most.

Besides the usual states I, S, O, M (exclusive clean) and MM (exclusive, possibly dirty), the line has two timed "write-locked" variants, M_W and MM_W. While the line is locked it refuses replacements and external DMA access. It falls back to M or MM when a programmable cycle count runs out. A store to M_W upgrades silently to MM_W. Four transient states cover outstanding requests: IS and IM (a miss with no copy), SM (an upgrade with a stale copy) and OM (data in hand, acknowledgments still due, counted down by an internal counter). Named transitions: load miss (I→IS), fill shared (IS→S), fill exclusive (IS→M_W), write miss (I→IM), upgrade (S/O→SM), grant (IM/SM→MM_W or OM), last ack (OM→MM_W), dirtying (M→MM), silent upgrade (M_W→MM_W), unlock (M_W→M, MM_W→MM), eviction (S/O/M/MM→I), invalidate (S→I, SM→IM), share-forward (owner→O) and exclusive-forward (owner→I).

Top module: `l1_line_coh`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) places the line in I. line_state encodes I=0, S=1, O=2, M=3, M_W=4, MM=5, MM_W=6, IS=7, IM=8, SM=9, OM=10. After reset, cpu_ack and msg_valid are low while no request is presented.
- R2: cpu_op encodes LOAD=0, STORE=1, REPLACE=2, and code 3 is never acknowledged. A load completes (cpu_ack high in the same cycle) in S, O, M, M_W, MM, MM_W, SM and OM. In I a load emits GETS (msg_type 0) and enters IS. In IS, net_msg DATA_S (0) moves the line to S and DATA_E (1) moves it to M_W, and in either case the waiting load completes in that same cycle.
- R3: A store completes at once in MM and MM_W. A store in M completes and moves the line to MM. A store in M_W completes and moves the line to MM_W with no message emitted.
- R4: A store in S or O emits GETX (msg_type 1) and enters SM. A store in I emits GETX and enters IM. Stores are stalled (no cpu_ack) in IS, IM, SM and OM.
- R5: DATA_X (net_msg 2) in IM or SM with net_acks zero moves the line to MM_W and completes a waiting store in the same cycle. With net_acks nonzero it moves the line to OM with that many acknowledgments due.
- R6: Each ACK (net_msg 3) in OM takes one off the count. The ACK that brings the count to zero moves the line to MM_W and completes a waiting store in that cycle.
- R7: A replacement completes in I (no change) and in S (to I, silently). In O and MM it completes, emits WB_DIRTY (msg_type 2) and goes to I. In M it completes, emits WB_CLEAN (msg_type 3) and goes to I. It is stalled in M_W, MM_W, IS, IM, SM and OM.
- R8: dma_grant equals dma_valid in every state except M_W and MM_W, where it stays low.
- R9: On each entry into M_W or MM_W, including the M_W→MM_W upgrade, the line stays locked for cfg_timeout+1 cycles unless an event moves it. It then drops to M (from M_W) or to MM (from MM_W).
- R10: INV (net_msg 4) always emits INV_ACK (msg_type 5). It moves S to I and SM to IM and leaves other states unchanged.
- R11: In O, M, M_W, MM and MM_W, FWD_GETS (net_msg 5) emits FWD_DATA (msg_type 4) and moves the line to O. FWD_GETX (net_msg 6) emits FWD_DATA and moves the line to I.
- R12: When net_valid is high, the network message is handled and the processor request is stalled. The only exception is a message that completes the waiting load or store (R2, R5, R6).
- R13: A network message with no meaning in the current state, such as DATA_S outside IS, ACK outside OM, or a forward in I, is dropped. It causes no state change and no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_timeout | input | TW | Lock length in cycles, minus one |
| cpu_valid | input | 1 | Processor request present (held while stalled) |
| cpu_op | input | 2 | Processor operation code |
| cpu_ack | output | 1 | Request completes this cycle |
| dma_valid | input | 1 | External DMA access request |
| dma_grant | output | 1 | DMA access accepted this cycle |
| net_valid | input | 1 | Incoming message present (always consumed) |
| net_msg | input | 3 | Incoming message code |
| net_acks | input | AW | Acknowledgments still due, carried with DATA_X |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 3 | Outgoing message code |
| line_state | output | 4 | Current coherence state code |

## Verification
A wrong state shows on line_state at the next clock, and it also changes cpu_ack, dma_grant and the emitted message in that cycle. A wrong acknowledgment count stays hidden until the ACK that should release OM arrives, either too early or too late. A wrong lock timer shows only when the unlock comes a cycle off, when a replacement or DMA access is granted inside the lock window, or when a lock outlives it. The bench therefore drives every stall and release boundary, and it compares all outputs every cycle against a behavioural model.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [3:0] {
        ST_I   = 4'd0,
        ST_S   = 4'd1,
        ST_O   = 4'd2,
        ST_M   = 4'd3,
        ST_MW  = 4'd4,
        ST_MM  = 4'd5,
        ST_MMW = 4'd6,
        ST_IS  = 4'd7,
        ST_IM  = 4'd8,
        ST_SM  = 4'd9,
        ST_OM  = 4'd10
    } line_st_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_REPL  = 2'd2,
        OP_NONE  = 2'd3
    } cpu_op_e;

    typedef enum logic [2:0] {
        IN_DATA_S   = 3'd0,
        IN_DATA_E   = 3'd1,
        IN_DATA_X   = 3'd2,
        IN_ACK      = 3'd3,
        IN_INV      = 3'd4,
        IN_FWD_GETS = 3'd5,
        IN_FWD_GETX = 3'd6,
        IN_RSVD     = 3'd7
    } net_msg_e;

    typedef enum logic [2:0] {
        OUT_GETS     = 3'd0,
        OUT_GETX     = 3'd1,
        OUT_WB_DIRTY = 3'd2,
        OUT_WB_CLEAN = 3'd3,
        OUT_FWD_DATA = 3'd4,
        OUT_INV_ACK  = 3'd5
    } out_msg_e;

endpackage

// File: rtl/coh_lock_timer.sv
module coh_lock_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          active,
    input  logic [TW-1:0] cfg_timeout,
    output logic          expired
);
    localparam logic [TW-1:0] ZERO = '0;
    localparam logic [TW-1:0] ONE  = TW'(1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= ZERO;
        end else if (restart) begin
            remain <= cfg_timeout;
        end else if (active && remain != ZERO) begin
            remain <= remain - ONE;
        end
    end

    assign expired = active && (remain == ZERO);

endmodule

// File: rtl/coh_ack_counter.sv
module coh_ack_counter #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    localparam logic [AW-1:0] ZERO = '0;
    localparam logic [AW-1:0] ONE  = AW'(1);

    logic [AW-1:0] due;

    always_ff @(posedge clk) begin
        if (rst) begin
            due <= ZERO;
        end else if (load) begin
            due <= load_val;
        end else if (dec && due != ZERO) begin
            due <= due - ONE;
        end
    end

    assign last = (due == ONE);

endmodule

// File: rtl/coh_line_fsm.sv
module coh_line_fsm
    import coh_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    input  logic          dma_valid,
    input  logic          net_valid,
    input  logic [2:0]    net_msg,
    input  logic [AW-1:0] net_acks,
    input  logic          tmr_expired,
    input  logic          cnt_last,
    output line_st_e      st,
    output logic          cpu_ack,
    output logic          dma_grant,
    output logic          msg_valid,
    output out_msg_e      msg_type,
    output logic          tmr_restart,
    output logic          tmr_active,
    output logic          cnt_load,
    output logic          cnt_dec
);
    localparam logic [AW-1:0] NO_ACKS = '0;

    line_st_e nxt;
    logic     is_locked;
    logic     is_owner;
    logic     do_ld;
    logic     do_st;
    logic     do_rp;
    net_msg_e in_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_I;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        in_code   = net_msg_e'(net_msg);
        is_locked = (st == ST_MW) || (st == ST_MMW);
        is_owner  = (st == ST_O) || (st == ST_M) || (st == ST_MW) ||
                    (st == ST_MM) || (st == ST_MMW);
        do_ld     = cpu_valid && (cpu_op_e'(cpu_op) == OP_LOAD);
        do_st     = cpu_valid && (cpu_op_e'(cpu_op) == OP_STORE);
        do_rp     = cpu_valid && (cpu_op_e'(cpu_op) == OP_REPL);

        nxt       = st;
        cpu_ack   = 1'b0;
        msg_valid = 1'b0;
        msg_type  = OUT_GETS;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        dma_grant = dma_valid && !is_locked;

        if (net_valid) begin
            unique case (in_code)
                IN_DATA_S: begin
                    if (st == ST_IS) begin
                        nxt     = ST_S;
                        cpu_ack = do_ld;
                    end
                end
                IN_DATA_E: begin
                    if (st == ST_IS) begin
                        nxt     = ST_MW;
                        cpu_ack = do_ld;
                    end
                end
                IN_DATA_X: begin
                    if (st == ST_IM || st == ST_SM) begin
                        if (net_acks == NO_ACKS) begin
                            nxt     = ST_MMW;
                            cpu_ack = do_st;
                        end else begin
                            nxt      = ST_OM;
                            cnt_load = 1'b1;
                        end
                    end
                end
                IN_ACK: begin
                    if (st == ST_OM) begin
                        if (cnt_last) begin
                            nxt     = ST_MMW;
                            cpu_ack = do_st;
                        end else begin
                            cnt_dec = 1'b1;
                        end
                    end
                end
                IN_INV: begin
                    msg_valid = 1'b1;
                    msg_type  = OUT_INV_ACK;
                    if (st == ST_S) begin
                        nxt = ST_I;
                    end else if (st == ST_SM) begin
                        nxt = ST_IM;
                    end
                end
                IN_FWD_GETS: begin
                    if (is_owner) begin
                        nxt       = ST_O;
                        msg_valid = 1'b1;
                        msg_type  = OUT_FWD_DATA;
                    end
                end
                IN_FWD_GETX: begin
                    if (is_owner) begin
                        nxt       = ST_I;
                        msg_valid = 1'b1;
                        msg_type  = OUT_FWD_DATA;
                    end
                end
                default: begin
                end
            endcase
        end else if (cpu_valid) begin
            unique case (st)
                ST_I: begin
                    if (do_ld) begin
                        nxt       = ST_IS;
                        msg_valid = 1'b1;
                        msg_type  = OUT_GETS;
                    end else if (do_st) begin
                        nxt       = ST_IM;
                        msg_valid = 1'b1;
                        msg_type  = OUT_GETX;
                    end else if (do_rp) begin
                        cpu_ack = 1'b1;
                    end
                end
                ST_S: begin
                    if (do_ld) begin
                        cpu_ack = 1'b1;
                    end else if (do_st) begin
                        nxt       = ST_SM;
                        msg_valid = 1'b1;
                        msg_type  = OUT_GETX;
                    end else if (do_rp) begin
                        nxt     = ST_I;
                        cpu_ack = 1'b1;
                    end
                end
                ST_O: begin
                    if (do_ld) begin
                        cpu_ack = 1'b1;
                    end else if (do_st) begin
                        nxt       = ST_SM;
                        msg_valid = 1'b1;
                        msg_type  = OUT_GETX;
                    end else if (do_rp) begin
                        nxt       = ST_I;
                        cpu_ack   = 1'b1;
                        msg_valid = 1'b1;
                        msg_type  = OUT_WB_DIRTY;
                    end
                end
                ST_M: begin
                    if (do_ld) begin
                        cpu_ack = 1'b1;
                    end else if (do_st) begin
                        nxt     = ST_MM;
                        cpu_ack = 1'b1;
                    end else if (do_rp) begin
                        nxt       = ST_I;
                        cpu_ack   = 1'b1;
                        msg_valid = 1'b1;
                        msg_type  = OUT_WB_CLEAN;
                    end
                end
                ST_MW: begin
                    if (do_ld) begin
                        cpu_ack = 1'b1;
                    end else if (do_st) begin
                        nxt     = ST_MMW;
                        cpu_ack = 1'b1;
                    end
                end
                ST_MM: begin
                    if (do_ld || do_st) begin
                        cpu_ack = 1'b1;
                    end else if (do_rp) begin
                        nxt       = ST_I;
                        cpu_ack   = 1'b1;
                        msg_valid = 1'b1;
                        msg_type  = OUT_WB_DIRTY;
                    end
                end
                ST_MMW: begin
                    cpu_ack = do_ld || do_st;
                end
                ST_SM, ST_OM: begin
                    cpu_ack = do_ld;
                end
                ST_IS, ST_IM: begin
                end
                default: begin
                end
            endcase
        end

        if (nxt == st && tmr_expired) begin
            nxt = (st == ST_MMW) ? ST_MM : ST_M;
        end

        tmr_active  = is_locked;
        tmr_restart = ((nxt == ST_MW) || (nxt == ST_MMW)) && (nxt != st);
    end

endmodule

// File: rtl/l1_line_coh.sv
module l1_line_coh
    import coh_pkg::*;
#(
    parameter int TW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] cfg_timeout,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    output logic          cpu_ack,
    input  logic          dma_valid,
    output logic          dma_grant,
    input  logic          net_valid,
    input  logic [2:0]    net_msg,
    input  logic [AW-1:0] net_acks,
    output logic          msg_valid,
    output logic [2:0]    msg_type,
    output logic [3:0]    line_state
);
    line_st_e st;
    out_msg_e mtype;
    logic     tmr_restart;
    logic     tmr_active;
    logic     tmr_expired;
    logic     cnt_load;
    logic     cnt_dec;
    logic     cnt_last;

    coh_line_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cpu_valid   (cpu_valid),
        .cpu_op      (cpu_op),
        .dma_valid   (dma_valid),
        .net_valid   (net_valid),
        .net_msg     (net_msg),
        .net_acks    (net_acks),
        .tmr_expired (tmr_expired),
        .cnt_last    (cnt_last),
        .st          (st),
        .cpu_ack     (cpu_ack),
        .dma_grant   (dma_grant),
        .msg_valid   (msg_valid),
        .msg_type    (mtype),
        .tmr_restart (tmr_restart),
        .tmr_active  (tmr_active),
        .cnt_load    (cnt_load),
        .cnt_dec     (cnt_dec)
    );

    coh_lock_timer #(.TW(TW)) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .restart     (tmr_restart),
        .active      (tmr_active),
        .cfg_timeout (cfg_timeout),
        .expired     (tmr_expired)
    );

    coh_ack_counter #(.AW(AW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (net_acks),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    assign line_state = st;
    assign msg_type   = mtype;

endmodule

// File: rtl/coh_line_checker.sv
module coh_line_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [TW-1:0] cfg_timeout,
    input logic          cpu_valid,
    input logic [1:0]    cpu_op,
    input logic          cpu_ack,
    input logic          dma_valid,
    input logic          dma_grant,
    input logic          net_valid,
    input logic          msg_valid,
    input logic [3:0]    line_state
);
    logic          locked;
    logic          transient;
    logic [3:0]    last_st;
    logic [TW:0]   run_q;
    logic [TW:0]   run_now;

    assign locked    = (line_state == 4'd4) || (line_state == 4'd6);
    assign transient = (line_state >= 4'd7);
    assign run_now   = (locked && line_state == last_st) ? run_q + 1'b1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_st <= 4'd0;
            run_q   <= '0;
        end else begin
            last_st <= line_state;
            run_q   <= run_now;
        end
    end

    // R8: no DMA access while the line is locked
    a_r8_dma_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && dma_valid) |-> !dma_grant);

    // R7: replacement never completes in a locked state
    a_r7_no_evict_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && cpu_valid && cpu_op == 2'd2) |-> !cpu_ack);

    // R3: silent upgrade emits nothing and lands in MM_W
    a_r3_silent_quiet: assert property (@(posedge clk) disable iff (rst)
        (line_state == 4'd4 && cpu_valid && cpu_op == 2'd1 && !net_valid) |-> !msg_valid);
    a_r3_silent_lands: assert property (@(posedge clk) disable iff (rst)
        (line_state == 4'd4 && cpu_valid && cpu_op == 2'd1 && !net_valid) |=> line_state == 4'd6);

    // R4: stores stall in every transient state without network help
    a_r4_store_stall: assert property (@(posedge clk) disable iff (rst)
        (transient && cpu_valid && cpu_op == 2'd1 && !net_valid) |-> !cpu_ack);

    // R9: a lock never outlasts its window
    a_r9_lock_window: assert property (@(posedge clk) disable iff (rst)
        locked |-> (run_now <= {1'b0, cfg_timeout}));

    // R9: leaving MM_W without an event goes to MM
    a_r9_mmw_exit: assert property (@(posedge clk) disable iff (rst)
        (line_state == 4'd6 && !net_valid) |=> (line_state == 4'd6 || line_state == 4'd5));

    // R12: a stable state does not serve the processor while a message is handled
    a_r12_net_first: assert property (@(posedge clk) disable iff (rst)
        (net_valid && !transient && cpu_valid) |-> !cpu_ack);

endmodule

bind l1_line_coh coh_line_checker #(.TW(TW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_timeout (cfg_timeout),
    .cpu_valid   (cpu_valid),
    .cpu_op      (cpu_op),
    .cpu_ack     (cpu_ack),
    .dma_valid   (dma_valid),
    .dma_grant   (dma_grant),
    .net_valid   (net_valid),
    .msg_valid   (msg_valid),
    .line_state  (line_state)
);

// File: tb/sim_l1_line_coh.sv
`timescale 1ns/1ps
module sim_l1_line_coh;
    localparam int TOUT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_timeout = 16'(TOUT);
    logic        cpu_valid = 1'b0;
    logic [1:0]  cpu_op = 2'd0;
    logic        cpu_ack;
    logic        dma_valid = 1'b0;
    logic        dma_grant;
    logic        net_valid = 1'b0;
    logic [2:0]  net_msg = 3'd0;
    logic [3:0]  net_acks = 4'd0;
    logic        msg_valid;
    logic [2:0]  msg_type;
    logic [3:0]  line_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st = 0;
    int m_tmr = 0;
    int m_due = 0;

    always #2.5 clk = ~clk;

    l1_line_coh u0 (
        .clk(clk), .rst(rst), .cfg_timeout(cfg_timeout),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ack(cpu_ack),
        .dma_valid(dma_valid), .dma_grant(dma_grant),
        .net_valid(net_valid), .net_msg(net_msg), .net_acks(net_acks),
        .msg_valid(msg_valid), .msg_type(msg_type), .line_state(line_state)
    );

    // One clock of stimulus; the model predicts and compares, then both advance.
    task automatic cyc(input bit cv, input int op, input bit dv,
                       input bit nv, input int nm, input int na, input string tag);
        int  nx, e_mt, act, exp_v;
        bit  e_ack, e_dma, e_mv, ld, sto, rp, lk, own;
        cpu_valid = cv; cpu_op = op[1:0]; dma_valid = dv;
        net_valid = nv; net_msg = nm[2:0]; net_acks = na[3:0];
        #1;
        nx = m_st; e_ack = 0; e_mv = 0; e_mt = 0;
        ld = cv && op == 0; sto = cv && op == 1; rp = cv && op == 2;
        lk = (m_st == 4 || m_st == 6);
        own = (m_st >= 2 && m_st <= 6);
        e_dma = dv && !lk;
        if (nv) begin
            if (nm == 0 && m_st == 7) begin nx = 1; e_ack = ld; end
            else if (nm == 1 && m_st == 7) begin nx = 4; e_ack = ld; end
            else if (nm == 2 && (m_st == 8 || m_st == 9)) begin
                if (na == 0) begin nx = 6; e_ack = sto; end
                else nx = 10;
            end else if (nm == 3 && m_st == 10) begin
                if (m_due == 1) begin nx = 6; e_ack = sto; end
            end else if (nm == 4) begin
                e_mv = 1; e_mt = 5;
                if (m_st == 1) nx = 0; else if (m_st == 9) nx = 8;
            end else if ((nm == 5 || nm == 6) && own) begin
                e_mv = 1; e_mt = 4; nx = (nm == 5) ? 2 : 0;
            end
        end else if (cv) begin
            if (ld) begin
                if (m_st == 0) begin nx = 7; e_mv = 1; e_mt = 0; end
                else if (m_st != 7 && m_st != 8) e_ack = 1;
            end else if (sto) begin
                if (m_st == 0) begin nx = 8; e_mv = 1; e_mt = 1; end
                else if (m_st == 1 || m_st == 2) begin nx = 9; e_mv = 1; e_mt = 1; end
                else if (m_st == 3) begin nx = 5; e_ack = 1; end
                else if (m_st == 4) begin nx = 6; e_ack = 1; end
                else if (m_st == 5 || m_st == 6) e_ack = 1;
            end else if (rp) begin
                if (m_st == 0) e_ack = 1;
                else if (m_st == 1) begin nx = 0; e_ack = 1; end
                else if (m_st == 2 || m_st == 5) begin nx = 0; e_ack = 1; e_mv = 1; e_mt = 2; end
                else if (m_st == 3) begin nx = 0; e_ack = 1; e_mv = 1; e_mt = 3; end
            end
        end
        if (nx == m_st && lk && m_tmr == 0) nx = (m_st == 6) ? 5 : 3;

        act   = {line_state, cpu_ack, dma_grant, msg_valid, (msg_valid ? msg_type : 3'd0)};
        exp_v = {m_st[3:0], e_ack, e_dma, e_mv, (e_mv ? e_mt[2:0] : 3'd0)};
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: st/ack/dma/mv/mt actual %h expected %h", tag, act, exp_v);
        end
        @(posedge clk);
        if ((nx == 4 || nx == 6) && nx != m_st) m_tmr = TOUT;
        else if (lk && m_tmr > 0) m_tmr--;
        if (nv && nm == 2 && (m_st == 8 || m_st == 9) && na != 0) m_due = na;
        else if (nv && nm == 3 && m_st == 10 && m_due > 0) m_due--;
        m_st = nx;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(1, "R1");
        // load miss, exclusive fill, lock behaviour
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 1, 1, 0, "R2");
        cyc(1, 2, 1, 0, 0, 0, "R7");
        cyc(0, 0, 1, 0, 0, 0, "R8");
        idle(3, "R9");
        cyc(0, 0, 1, 0, 0, 0, "R8");
        cyc(1, 1, 0, 0, 0, 0, "R3");
        cyc(1, 2, 0, 0, 0, 0, "R7");
        // shared fill, priority, upgrade with acks
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 1, 0, 0, "R2");
        cyc(1, 0, 0, 1, 4, 0, "R12");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 1, 0, 0, "R2");
        cyc(1, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 0, 0, 0, "R4");
        cyc(1, 1, 0, 0, 0, 0, "R4");
        cyc(1, 2, 0, 0, 0, 0, "R7");
        cyc(1, 1, 0, 1, 2, 2, "R5");
        cyc(1, 1, 0, 0, 0, 0, "R4");
        cyc(1, 1, 0, 1, 3, 0, "R6");
        cyc(1, 1, 0, 1, 3, 0, "R6");
        cyc(0, 0, 1, 0, 0, 0, "R8");
        idle(4, "R9");
        // forwards and invalidations
        cyc(0, 0, 0, 1, 5, 0, "R11");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 1, 0, 0, 0, 0, "R4");
        cyc(1, 1, 0, 1, 4, 0, "R10");
        cyc(1, 1, 0, 1, 2, 0, "R5");
        cyc(0, 0, 0, 1, 6, 0, "R11");
        cyc(0, 0, 0, 1, 3, 0, "R13");
        cyc(0, 0, 0, 1, 0, 0, "R13");
        cyc(0, 0, 0, 1, 5, 0, "R13");
        cyc(0, 0, 0, 1, 4, 0, "R10");
        cyc(1, 3, 0, 0, 0, 0, "R2");
        // silent upgrade restarts the lock
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 1, 1, 0, "R2");
        idle(1, "R9");
        cyc(1, 1, 0, 0, 0, 0, "R3");
        idle(5, "R9");
        // write miss with one ack
        cyc(1, 2, 0, 0, 0, 0, "R7");
        cyc(1, 1, 0, 0, 0, 0, "R4");
        cyc(1, 1, 0, 1, 2, 1, "R5");
        cyc(1, 1, 0, 1, 3, 0, "R6");
        cyc(0, 0, 0, 1, 6, 0, "R11");
        // mixed stimulus against the model
        for (int i = 0; i < 2000; i++) begin
            int r, nm;
            r  = $urandom_range(0, 99);
            nm = $urandom_range(0, 6);
            cyc(r < 60, $urandom_range(0, 3), r[0], r > 70, nm,
                $urandom_range(0, 3), "R12");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule